// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core whose register set is organised as a ring of overlapping windows. At any moment software sees 32 registers, addressed by a 5-bit index. Eight of them are globals that every window shares. The other 24 belong to the current window, which a window pointer selects. Each window has eight private locals. Its eight "in" registers are the same storage as the eight "out" registers of the window one step higher. A callee that moves down one window therefore finds its caller's outgoing arguments already in its own in registers.

The core drives two combinational read ports, one write port and a window-change command on every cycle. A save moves the pointer down by one. A restore or a return-from-trap moves it up by one. Trap entry also moves it down. The pointer wraps modulo the window count. An invalid-window mask names the window that may not be entered. A save that would land on a masked window raises an overflow flag. A restore or return-from-trap that would land on one raises an underflow flag. A flagged command leaves the pointer and the registers unchanged, and the core's trap logic then takes over. The window count is a parameter from 2 to 32, and the block holds 8 + 16 × count physical registers.

Top module: `winreg_file`

## Requirements
- R1: After reset the window pointer is 0, the invalid-window mask is 0, and every register reads as 0.
- R2: Index 0 always reads as 0 on both read ports, and a write to index 0 changes nothing.
- R3: Indices 1 to 7 are globals: a value written in one window reads back unchanged from every other window.
- R4: Indices 16 to 23 are locals that belong to one window only. A write in window w is not visible in any other window, and it is visible again when the pointer returns to w.
- R5: Indices 8 to 15 (outs) of window w and indices 24 to 31 (ins) of window w−1 (mod count) address the same registers, with out k matching in k+16.
- R6: The command code win_op is 0 none, 1 save, 2 restore, 3 trap entry, 4 return-from-trap; codes 5 to 7 act as none. Save and trap entry decrement the pointer, and restore and return-from-trap increment it, modulo the window count (0 − 1 gives count − 1).
- R7: In a cycle with a window change, the read ports address the old window and the write port addresses the new window.
- R8: A save whose target window has its mask bit set raises ovf_trap in that cycle. The pointer keeps its value and that cycle's register write is dropped.
- R9: A restore or return-from-trap whose target window has its mask bit set raises unf_trap in that cycle. The pointer keeps its value and that cycle's register write is dropped.
- R10: Trap entry moves the pointer even onto a masked window and never raises either flag.
- R11: A mask write takes effect from the next cycle, so a window change in the same cycle uses the old mask. Mask bits at or above the window count always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_op | input | 3 | Window command for this cycle (R6 encoding) |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | XLEN | Read port A data, combinational |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | XLEN | Read port B data, combinational |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Write register index, taken in the new window |
| wr_data | input | XLEN | Write data |
| wim_we | input | 1 | Load the invalid-window mask |
| wim_wdata | input | 32 | New mask value |
| cwp | output | 5 | Current window pointer |
| wim | output | 32 | Current invalid-window mask |
| ovf_trap | output | 1 | Save refused: target window invalid |
| unf_trap | output | 1 | Restore or return refused: target window invalid |

## Verification
The bench builds the block with five windows and 32-bit data. A count that is not a power of two means the pointer must wrap from 0 to 4 and from 4 to 0 by an explicit comparison, because dropping the upper bits would not wrap correctly. Five windows also leave 27 mask bits above the top window, which lets a full-ones mask write show that those bits read as zero. With so few windows, random mask and command traffic often hits the invalid window from both directions, and it also crosses the ring seam where window 4's ins are window 0's outs.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    localparam int unsigned GLOB_REGS = 8;
    localparam int unsigned WIN_REGS  = 16;
    localparam int unsigned PTR_W     = 5;
    localparam int unsigned MASK_W    = 32;

    typedef enum logic [2:0] {
        WOP_NONE    = 3'd0,
        WOP_SAVE    = 3'd1,
        WOP_RESTORE = 3'd2,
        WOP_TRAP    = 3'd3,
        WOP_RETT    = 3'd4
    } win_op_e;

    typedef struct packed {
        logic [PTR_W-1:0]  cwp;
        logic [MASK_W-1:0] wim;
    } ctl_state_t;

endpackage

// File: rtl/winreg_map.sv
module winreg_map
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int PW   = 8
) (
    input  logic [4:0]    win,
    input  logic [4:0]    idx,
    output logic [PW-1:0] phys
);
    localparam int BASE0   = int'(GLOB_REGS);
    localparam int STRIDE  = int'(WIN_REGS);
    localparam int OUT_OFS = 8;

    logic [4:0] win_up;
    int         loc_base;
    int         up_base;

    always_comb begin
        win_up   = (win == 5'(NWIN - 1)) ? 5'd0 : win + 5'd1;
        loc_base = BASE0 + STRIDE * int'(win);
        up_base  = BASE0 + STRIDE * int'(win_up);
        case (idx[4:3])
            2'b00:   phys = PW'(int'(idx));
            2'b01:   phys = PW'(loc_base + OUT_OFS + int'(idx[2:0]));
            2'b10:   phys = PW'(loc_base + int'(idx[2:0]));
            default: phys = PW'(up_base + OUT_OFS + int'(idx[2:0]));
        endcase
    end

endmodule

// File: rtl/winreg_ctl.sv
module winreg_ctl
    import winreg_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        win_op,
    input  logic              wim_we,
    input  logic [MASK_W-1:0] wim_wdata,
    output logic [PTR_W-1:0]  cwp_q,
    output logic [PTR_W-1:0]  cwp_tgt,
    output logic [MASK_W-1:0] wim_q,
    output logic              ovf,
    output logic              unf,
    output logic              commit
);
    localparam logic [MASK_W:0]   ONE_SH   = (MASK_W+1)'(1) << NWIN;
    localparam logic [MASK_W-1:0] WIM_MASK = MASK_W'(ONE_SH - (MASK_W+1)'(1));
    localparam logic [PTR_W-1:0]  TOP_WIN  = PTR_W'(NWIN - 1);

    ctl_state_t st_d, st_q;
    logic [PTR_W-1:0] cwp_dn, cwp_up;

    always_comb begin
        st_d    = st_q;
        cwp_dn  = (st_q.cwp == '0) ? TOP_WIN : st_q.cwp - PTR_W'(1);
        cwp_up  = (st_q.cwp == TOP_WIN) ? '0 : st_q.cwp + PTR_W'(1);
        cwp_tgt = st_q.cwp;
        ovf     = 1'b0;
        unf     = 1'b0;
        case (win_op)
            WOP_SAVE: begin
                cwp_tgt = cwp_dn;
                ovf     = st_q.wim[cwp_dn];
            end
            WOP_RESTORE, WOP_RETT: begin
                cwp_tgt = cwp_up;
                unf     = st_q.wim[cwp_up];
            end
            WOP_TRAP: cwp_tgt = cwp_dn;
            default: ;
        endcase
        commit = !(ovf || unf);
        if (commit) st_d.cwp = cwp_tgt;
        if (wim_we) st_d.wim = wim_wdata & WIM_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp_q = st_q.cwp;
    assign wim_q = st_q.wim;

    // R6: save steps the pointer down with wrap
    a_r6_save_step: assert property (@(posedge clk) disable iff (!rst_n)
        (win_op == WOP_SAVE && !ovf) |=>
        cwp_q == (($past(cwp_q) == '0) ? TOP_WIN : $past(cwp_q) - PTR_W'(1)));

    // R6: restore steps the pointer up with wrap
    a_r6_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
        (win_op == WOP_RESTORE && !unf) |=>
        cwp_q == (($past(cwp_q) == TOP_WIN) ? '0 : $past(cwp_q) + PTR_W'(1)));

    // R6: pointer never leaves the ring
    a_r6_cwp_range: assert property (@(posedge clk) disable iff (!rst_n)
        cwp_q <= TOP_WIN);

    // R8, R9: a refused change leaves the pointer alone
    a_r8_hold_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf || unf) |=> $stable(cwp_q));

    // R10: trap entry always moves down
    a_r10_trap_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (win_op == WOP_TRAP) |=>
        cwp_q == (($past(cwp_q) == '0) ? TOP_WIN : $past(cwp_q) - PTR_W'(1)));

    // R11: mask load lands next cycle, bits above the ring cleared
    a_r11_wim_load: assert property (@(posedge clk) disable iff (!rst_n)
        wim_we |=> wim_q == ($past(wim_wdata) & WIM_MASK));

    a_r11_wim_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wim_q & ~WIM_MASK) == '0);

endmodule

// File: rtl/winreg_store.sv
module winreg_store #(
    parameter int NPHYS = 136,
    parameter int PW    = 8,
    parameter int XLEN  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [PW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [PW-1:0]   raddr_a,
    input  logic [PW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b
);
    logic [XLEN-1:0] regs_d [NPHYS];
    logic [XLEN-1:0] regs_q [NPHYS];

    always_comb begin
        regs_d = regs_q;
        if (we && int'(waddr) < NPHYS) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{default: '0};
        else        regs_q <= regs_d;
    end

    assign rdata_a = (int'(raddr_a) < NPHYS) ? regs_q[raddr_a] : '0;
    assign rdata_b = (int'(raddr_b) < NPHYS) ? regs_q[raddr_b] : '0;

    // R2: the zero slot is never written
    a_r2_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> waddr != '0);

    // R2: zero slot stays zero
    a_r2_slot0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[0] == '0);

endmodule

// File: rtl/winreg_file.sv
module winreg_file
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      win_op,
    input  logic [4:0]      rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [4:0]      rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            wim_we,
    input  logic [31:0]     wim_wdata,
    output logic [4:0]      cwp,
    output logic [31:0]     wim,
    output logic            ovf_trap,
    output logic            unf_trap
);
    localparam int NPHYS = int'(GLOB_REGS) + int'(WIN_REGS) * NWIN;
    localparam int PW    = $clog2(NPHYS);

    logic [PTR_W-1:0] cwp_q, cwp_tgt;
    logic             commit;
    logic [PW-1:0]    pa, pb, pw;
    logic [XLEN-1:0]  sa, sb;
    logic             st_we;

    winreg_ctl #(.NWIN(NWIN)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_op   (win_op),
        .wim_we   (wim_we),
        .wim_wdata(wim_wdata),
        .cwp_q    (cwp_q),
        .cwp_tgt  (cwp_tgt),
        .wim_q    (wim),
        .ovf      (ovf_trap),
        .unf      (unf_trap),
        .commit   (commit)
    );

    winreg_map #(.NWIN(NWIN), .PW(PW)) u_map_a (.win(cwp_q),   .idx(rd_a_idx), .phys(pa));
    winreg_map #(.NWIN(NWIN), .PW(PW)) u_map_b (.win(cwp_q),   .idx(rd_b_idx), .phys(pb));
    winreg_map #(.NWIN(NWIN), .PW(PW)) u_map_w (.win(cwp_tgt), .idx(wr_idx),   .phys(pw));

    assign st_we = wr_en && commit && (wr_idx != 5'd0);

    winreg_store #(.NPHYS(NPHYS), .PW(PW), .XLEN(XLEN)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (st_we),
        .waddr  (pw),
        .wdata  (wr_data),
        .raddr_a(pa),
        .raddr_b(pb),
        .rdata_a(sa),
        .rdata_b(sb)
    );

    assign rd_a_data = (rd_a_idx == 5'd0) ? '0 : sa;
    assign rd_b_data = (rd_b_idx == 5'd0) ? '0 : sb;
    assign cwp       = cwp_q;

    // R8: an overflow never lets a write through
    a_r8_no_write_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> !st_we);

    // R9: an underflow never lets a write through
    a_r9_no_write_on_unf: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |-> !st_we);

    // R8, R9: at most one flag at a time
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_trap && unf_trap));

endmodule

// File: tb/test_winreg_file.sv
`timescale 1ns/1ps
module test_winreg_file;
    localparam int NW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  win_op = '0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, wim_wdata = '0, wim;
    logic        wr_en = 1'b0, wim_we = 1'b0, ovf_trap, unf_trap;
    logic [4:0]  cwp;

    always #5 clk = ~clk;

    winreg_file #(.NWIN(NW), .XLEN(32)) i_winreg_file (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_glob [8];
    logic [31:0] m_out  [NW][8];
    logic [31:0] m_loc  [NW][8];
    int          m_cwp;
    logic [31:0] m_wim;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int dn(input int w); return (w == 0) ? NW - 1 : w - 1; endfunction
    function automatic int up(input int w); return (w == NW - 1) ? 0 : w + 1; endfunction

    function automatic logic [31:0] mrd(input int w, input logic [4:0] i);
        if (i == 0)       return '0;
        else if (i < 8)   return m_glob[i];
        else if (i < 16)  return m_out[w][i-8];
        else if (i < 24)  return m_loc[w][i-16];
        else              return m_out[up(w)][i-24];
    endfunction

    function automatic string tag_of(input logic [4:0] i);
        if (i == 0)      return "R2 zero";
        else if (i < 8)  return "R3 global";
        else if (i < 16) return "R5 out";
        else if (i < 24) return "R4 local";
        else             return "R5 in";
    endfunction

    task automatic mwr(input int w, input logic [4:0] i, input logic [31:0] d);
        if (i == 0) return;
        else if (i < 8)  m_glob[i] = d;
        else if (i < 16) m_out[w][i-8] = d;
        else if (i < 24) m_loc[w][i-16] = d;
        else             m_out[up(w)][i-24] = d;
    endtask

    task automatic step(input logic [2:0] op, input logic we, input logic [4:0] wi,
                        input logic [31:0] wd, input logic [4:0] ra, input logic [4:0] rb,
                        input logic ww, input logic [31:0] wv);
        int  tgt;
        bit  e_ovf, e_unf;
        @(negedge clk);
        win_op = op; wr_en = we; wr_idx = wi; wr_data = wd;
        rd_a_idx = ra; rd_b_idx = rb; wim_we = ww; wim_wdata = wv;
        #1;
        tgt = m_cwp; e_ovf = 0; e_unf = 0;
        case (op)
            3'd1: begin tgt = dn(m_cwp); e_ovf = m_wim[tgt]; end
            3'd2, 3'd4: begin tgt = up(m_cwp); e_unf = m_wim[tgt]; end
            3'd3: tgt = dn(m_cwp);
            default: ;
        endcase
        chk({tag_of(ra), " rdA (R7 old window)"}, rd_a_data, mrd(m_cwp, ra));
        chk({tag_of(rb), " rdB (R7 old window)"}, rd_b_data, mrd(m_cwp, rb));
        chk("R8 ovf_trap", 32'(ovf_trap), 32'(e_ovf));
        chk("R9 unf_trap (R10 trap entry)", 32'(unf_trap), 32'(e_unf));
        @(posedge clk);
        if (!(e_ovf || e_unf)) begin
            m_cwp = tgt;
            if (we) mwr(tgt, wi, wd);
        end
        if (ww) m_wim = wv & 32'h0000_001F;
        #1;
        chk("R6 cwp", 32'(cwp), 32'(m_cwp));
        chk("R11 wim", wim, m_wim);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        foreach (m_glob[i]) m_glob[i] = '0;
        for (int w = 0; w < NW; w++)
            for (int k = 0; k < 8; k++) begin m_out[w][k] = '0; m_loc[w][k] = '0; end
        m_cwp = 0; m_wim = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 cwp reset", 32'(cwp), 0);
        chk("R1 wim reset", wim, 0);
        rd_a_idx = 5'd17; rd_b_idx = 5'd30; #1;
        chk("R1 regs reset A", rd_a_data, 0);
        chk("R1 regs reset B", rd_b_data, 0);

        // R2 write to zero register
        step(3'd0, 1, 5'd0, 32'hDEAD_BEEF, 5'd0, 5'd0, 0, 0);
        step(3'd0, 0, 5'd0, 0, 5'd0, 5'd3, 0, 0);
        chk("R2 zero after write", rd_a_data, 0);
        // R3 global then save across wrap 0 -> 4 (R6)
        step(3'd0, 1, 5'd3, 32'hA5A5_0003, 5'd0, 5'd0, 0, 0);
        step(3'd1, 0, 5'd0, 0, 5'd3, 5'd0, 0, 0);
        chk("R6 wrap 0 to 4", 32'(cwp), 4);
        step(3'd0, 0, 0, 0, 5'd3, 5'd0, 0, 0);
        chk("R3 global seen in window 4", rd_a_data, 32'hA5A5_0003);
        // R4/R5: local and out in window 4, then save to 3
        step(3'd0, 1, 5'd16, 32'h0000_B016, 0, 0, 0, 0);
        step(3'd0, 1, 5'd9,  32'h0000_C009, 0, 0, 0, 0);
        step(3'd1, 0, 0, 0, 5'd16, 5'd9, 0, 0);
        step(3'd0, 0, 0, 0, 5'd25, 5'd16, 0, 0);
        chk("R5 out9 of w4 is in25 of w3", rd_a_data, 32'h0000_C009);
        chk("R4 local private in w3", rd_b_data, 0);
        // R7: restore reads old window, writes new window
        step(3'd2, 1, 5'd17, 32'h0000_D017, 5'd25, 5'd0, 0, 0);
        step(3'd0, 0, 0, 0, 5'd17, 5'd16, 0, 0);
        chk("R7 write landed in new window 4", rd_a_data, 32'h0000_D017);
        chk("R4 local back in w4", rd_b_data, 32'h0000_B016);
        // R8: mark window 3 invalid, save refused, write dropped
        step(3'd0, 0, 0, 0, 0, 0, 1, 32'h0000_0008);
        step(3'd1, 1, 5'd18, 32'h0000_E018, 0, 0, 0, 0);
        chk("R8 cwp held", 32'(cwp), 4);
        step(3'd0, 0, 0, 0, 5'd18, 0, 0, 0);
        chk("R8 write dropped", rd_a_data, 0);
        // R10: trap entry onto invalid window 3
        step(3'd3, 0, 0, 0, 0, 0, 0, 0);
        chk("R10 trap entry moved", 32'(cwp), 3);
        // R9: window 4 invalid, return-from-trap refused
        step(3'd0, 0, 0, 0, 0, 0, 1, 32'h0000_0010);
        step(3'd4, 1, 5'd5, 32'h1234_0005, 0, 0, 0, 0);
        chk("R9 rett held", 32'(cwp), 3);
        // R11: mask write in same cycle as restore uses old mask
        step(3'd2, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
        chk("R11 old mask used", 32'(cwp), 3);
        chk("R11 high bits cleared", wim, 32'h0000_001F);
        step(3'd0, 0, 0, 0, 0, 0, 1, 0);
        // R6: codes 5..7 act as none
        step(3'd6, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 code 6 no move", 32'(cwp), 3);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] wv;
            bit          ww;
            int          sel;
            ww = ($urandom % 6) == 0;
            sel = $urandom % 4;
            wv = (sel == 0) ? 32'h0 : (sel == 3) ? $urandom : (32'h1 << ($urandom % NW));
            step(3'($urandom % 8), 1'($urandom % 2), 5'($urandom), $urandom,
                 5'($urandom), 5'($urandom), ww, wv);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule